// File: doc/BRIEF.md
# Interrupt entry sequencer

This block carries out the fixed hardware steps a 16-bit CPU performs after its priority arbiter has granted an interrupt. After a one-cycle accept strobe, it reads the interrupt number and request level from the acknowledge location. It then clears the pending bit of that source and keeps a private copy of the flag word as it stood before the sequence. Next it writes back a modified flag word and selects the stack pointer that the new flags imply. It pushes the saved flags and then the two halves of the program counter, stores the accepted level into the processor priority field, and fetches the handler start address from a vector read port.

The block finishes with a one-cycle done pulse. In that cycle it also writes the new program counter and the final stack pointer, and the CPU resumes execution at the handler. Both the stack write port and the vector read port use a valid/ready handshake. Valid rises when the step is reached and stays high with address and data stable until ready is seen high at a clock edge. Ready may stay low for any number of cycles, and the sequence waits without loss. The other pins are plain one-cycle strobes.

Top module: `isc_entry_seq`

## Requirements
- R1: When idle, an accept strobe sampled at a clock edge makes `ack_rd_o` high for exactly the next cycle, with `ack_addr_o` equal to the parameter ACK_ADDR (default 0); number and level are taken from `ack_num_i`/`ack_lvl_i` in that cycle.
- R2: In the cycle after the acknowledge read, `clr_pend_o` pulses for one cycle with `clr_num_o` equal to the acknowledged number.
- R3: In the next cycle `flg_wr_o` pulses, and `flg_o` equals the flag word present during the acknowledge cycle with the interrupt enable bit (bit 6) and the single-step bit (bit 1) cleared. All other bits are kept, except as set out in R4.
- R4: The stack-select bit (bit 7) is cleared in `flg_o`, except when `sw_int_i` was high at accept and the number is 32 to 63, in which case it keeps its old value.
- R5: Exactly three stack writes follow, in this order: the saved pre-sequence flags, then PC bits 19:16 zero-extended to 16 bits, then PC bits 15:0. The first address is S-1 and each later address is one below the previous one, where S is `usp_i` if the new bit 7 is 1 and `isp_i` otherwise.
- R6: While `stk_valid_o` is high and `stk_ready_i` is low, valid, address and data stay unchanged at the next cycle.
- R7: After the pushes, `ipl_wr_o` pulses for one cycle with `ipl_o` equal to the acknowledged level.
- R8: `vec_rd_valid_o` is then raised with `vec_rd_num_o` equal to the number, and held with a stable number until `vec_rd_ready_i`. The `vec_rd_data_i` value seen in that cycle becomes the new program counter.
- R9: `done_o` pulses for one cycle together with `pc_wr_o` (`pc_o` = vector data) and `sp_wr_o` (`sp_new_o` = S-3). With both ready inputs held high, `done_o` appears in the ninth cycle after the accept edge.
- R10: An accept strobe arriving while `busy_o` is high is ignored: no second acknowledge read, push or done follows it.
- R11: After reset, `busy_o` and every strobe and valid output are low, and at most one of the step strobes (ack, clear, flag, level, done) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_accept_i | input | 1 | Interrupt accept strobe from the arbiter |
| sw_int_i | input | 1 | Accepted interrupt is a software interrupt |
| ack_rd_o | output | 1 | Acknowledge read strobe |
| ack_addr_o | output | 20 | Fixed acknowledge address |
| ack_num_i | input | 6 | Interrupt number returned by acknowledge read |
| ack_lvl_i | input | 3 | Request level returned by acknowledge read |
| clr_pend_o | output | 1 | Clear pending bit strobe |
| clr_num_o | output | 6 | Source whose pending bit is cleared |
| flg_i | input | 16 | Current flag word |
| flg_wr_o | output | 1 | Flag word write strobe |
| flg_o | output | 16 | New flag word |
| isp_i | input | 16 | Interrupt stack pointer |
| usp_i | input | 16 | User stack pointer |
| pc_i | input | 20 | Program counter of the interrupted code |
| stk_valid_o | output | 1 | Stack write valid |
| stk_ready_i | input | 1 | Stack write ready |
| stk_addr_o | output | 16 | Stack write word address |
| stk_data_o | output | 16 | Stack write data |
| ipl_wr_o | output | 1 | Priority level write strobe |
| ipl_o | output | 3 | New processor priority level |
| vec_rd_valid_o | output | 1 | Vector read request valid |
| vec_rd_ready_i | input | 1 | Vector read ready, data valid in same cycle |
| vec_rd_num_o | output | 6 | Vector index to read |
| vec_rd_data_i | input | 20 | Handler start address |
| pc_wr_o | output | 1 | Program counter write strobe |
| pc_o | output | 20 | New program counter |
| sp_wr_o | output | 1 | Stack pointer write strobe |
| sp_new_o | output | 16 | Stack pointer after the pushes |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Execution may resume |

## Verification
The bench builds the block with its default parameters: 16-bit flag and stack words, a 20-bit program counter, and 6-bit interrupt numbers with the stack-select exception starting at 32. With these values a 6-bit number covers the whole range, so the bench can reach both edges of the software exception (31 and 32, plus 63). A 20-bit program counter leaves a non-empty upper push word, so the zero extension of that word can be seen at the stack port. The fixed flag bit positions let chosen flag words show clearing and keeping of each bit at once.

// File: rtl/isc_pkg.sv
package isc_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_ACK,
    S_CLR,
    S_FLG,
    S_PSH_F,
    S_PSH_H,
    S_PSH_L,
    S_IPL,
    S_VEC,
    S_DONE
  } isc_state_e;
endpackage

// File: rtl/isc_fsm.sv
module isc_fsm
  import isc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic       stk_hs,
  input  logic       vec_hs,
  output isc_state_e state
);
  isc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE:  if (accept) nxt = S_ACK;
      S_ACK:   nxt = S_CLR;
      S_CLR:   nxt = S_FLG;
      S_FLG:   nxt = S_PSH_F;
      S_PSH_F: if (stk_hs) nxt = S_PSH_H;
      S_PSH_H: if (stk_hs) nxt = S_PSH_L;
      S_PSH_L: if (stk_hs) nxt = S_IPL;
      S_IPL:   nxt = S_VEC;
      S_VEC:   if (vec_hs) nxt = S_DONE;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/isc_flag_mod.sv
module isc_flag_mod #(
  parameter int FW         = 16,
  parameter int NUM_W      = 6,
  parameter int I_BIT      = 6,
  parameter int D_BIT      = 1,
  parameter int U_BIT      = 7,
  parameter int SW_KEEP_LO = 32
) (
  input  logic [FW-1:0]    flg_old,
  input  logic             sw,
  input  logic [NUM_W-1:0] num,
  output logic [FW-1:0]    flg_new
);
  logic keep_u;

  always_comb begin
    keep_u  = sw && (int'(num) >= SW_KEEP_LO);
    flg_new = flg_old;
    flg_new[I_BIT] = 1'b0;
    flg_new[D_BIT] = 1'b0;
    if (!keep_u) flg_new[U_BIT] = 1'b0;
  end
endmodule

// File: rtl/isc_stack.sv
module isc_stack
  import isc_pkg::*;
#(
  parameter int FW   = 16,
  parameter int SP_W = 16,
  parameter int PC_W = 20
) (
  input  logic            clk,
  input  logic            rst_n,
  input  isc_state_e      state,
  input  logic            use_usp,
  input  logic [SP_W-1:0] isp,
  input  logic [SP_W-1:0] usp,
  input  logic [FW-1:0]   saved_flg,
  input  logic [PC_W-1:0] saved_pc,
  input  logic            ready,
  output logic            valid,
  output logic [SP_W-1:0] addr,
  output logic [FW-1:0]   data,
  output logic [SP_W-1:0] sp
);
  localparam int HI_W = PC_W - FW;

  logic [FW-1:0] pc_hi;
  logic [FW-1:0] pc_lo;

  assign pc_hi = {{(2*FW-PC_W){1'b0}}, saved_pc[PC_W-1:FW]};
  assign pc_lo = saved_pc[FW-1:0];
  assign valid = (state == S_PSH_F) || (state == S_PSH_H) || (state == S_PSH_L);
  assign addr  = sp - SP_W'(1);

  always_comb begin
    unique case (state)
      S_PSH_H: data = pc_hi;
      S_PSH_L: data = pc_lo;
      default: data = saved_flg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 sp <= '0;
    else if (state == S_FLG)    sp <= use_usp ? usp : isp;
    else if (valid && ready)    sp <= addr;
  end

  if (HI_W < 1 || HI_W > FW) begin : g_bad_pc_w
    initial $error("isc_stack: PC_W must exceed FW and fit in two words");
  end
endmodule

// File: rtl/isc_entry_seq.sv
module isc_entry_seq
  import isc_pkg::*;
#(
  parameter int              FW         = 16,
  parameter int              SP_W       = 16,
  parameter int              PC_W       = 20,
  parameter int              NUM_W      = 6,
  parameter int              LVL_W      = 3,
  parameter int              I_BIT      = 6,
  parameter int              D_BIT      = 1,
  parameter int              U_BIT      = 7,
  parameter int              SW_KEEP_LO = 32,
  parameter logic [PC_W-1:0] ACK_ADDR   = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             int_accept_i,
  input  logic             sw_int_i,
  output logic             ack_rd_o,
  output logic [PC_W-1:0]  ack_addr_o,
  input  logic [NUM_W-1:0] ack_num_i,
  input  logic [LVL_W-1:0] ack_lvl_i,
  output logic             clr_pend_o,
  output logic [NUM_W-1:0] clr_num_o,
  input  logic [FW-1:0]    flg_i,
  output logic             flg_wr_o,
  output logic [FW-1:0]    flg_o,
  input  logic [SP_W-1:0]  isp_i,
  input  logic [SP_W-1:0]  usp_i,
  input  logic [PC_W-1:0]  pc_i,
  output logic             stk_valid_o,
  input  logic             stk_ready_i,
  output logic [SP_W-1:0]  stk_addr_o,
  output logic [FW-1:0]    stk_data_o,
  output logic             ipl_wr_o,
  output logic [LVL_W-1:0] ipl_o,
  output logic             vec_rd_valid_o,
  input  logic             vec_rd_ready_i,
  output logic [NUM_W-1:0] vec_rd_num_o,
  input  logic [PC_W-1:0]  vec_rd_data_i,
  output logic             pc_wr_o,
  output logic [PC_W-1:0]  pc_o,
  output logic             sp_wr_o,
  output logic [SP_W-1:0]  sp_new_o,
  output logic             busy_o,
  output logic             done_o
);
  isc_state_e state;

  logic             sw_q;
  logic [NUM_W-1:0] num_q;
  logic [LVL_W-1:0] lvl_q;
  logic [FW-1:0]    tmp_flg_q;
  logic [PC_W-1:0]  pc_q;
  logic [PC_W-1:0]  vec_q;
  logic [FW-1:0]    flg_new;
  logic             stk_hs;
  logic             vec_hs;
  logic [SP_W-1:0]  sp_cur;

  assign stk_hs = stk_valid_o && stk_ready_i;
  assign vec_hs = vec_rd_valid_o && vec_rd_ready_i;

  isc_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (int_accept_i),
    .stk_hs (stk_hs),
    .vec_hs (vec_hs),
    .state  (state)
  );

  isc_flag_mod #(
    .FW(FW), .NUM_W(NUM_W), .I_BIT(I_BIT), .D_BIT(D_BIT),
    .U_BIT(U_BIT), .SW_KEEP_LO(SW_KEEP_LO)
  ) u_flag (
    .flg_old (tmp_flg_q),
    .sw      (sw_q),
    .num     (num_q),
    .flg_new (flg_new)
  );

  isc_stack #(.FW(FW), .SP_W(SP_W), .PC_W(PC_W)) u_stack (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .use_usp   (flg_new[U_BIT]),
    .isp       (isp_i),
    .usp       (usp_i),
    .saved_flg (tmp_flg_q),
    .saved_pc  (pc_q),
    .ready     (stk_ready_i),
    .valid     (stk_valid_o),
    .addr      (stk_addr_o),
    .data      (stk_data_o),
    .sp        (sp_cur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q      <= 1'b0;
      num_q     <= '0;
      lvl_q     <= '0;
      tmp_flg_q <= '0;
      pc_q      <= '0;
      vec_q     <= '0;
    end else begin
      if (state == S_IDLE && int_accept_i) sw_q <= sw_int_i;
      if (state == S_ACK) begin
        num_q     <= ack_num_i;
        lvl_q     <= ack_lvl_i;
        tmp_flg_q <= flg_i;
        pc_q      <= pc_i;
      end
      if (vec_hs) vec_q <= vec_rd_data_i;
    end
  end

  assign ack_rd_o       = (state == S_ACK);
  assign ack_addr_o     = ACK_ADDR;
  assign clr_pend_o     = (state == S_CLR);
  assign clr_num_o      = num_q;
  assign flg_wr_o       = (state == S_FLG);
  assign flg_o          = flg_new;
  assign ipl_wr_o       = (state == S_IPL);
  assign ipl_o          = lvl_q;
  assign vec_rd_valid_o = (state == S_VEC);
  assign vec_rd_num_o   = num_q;
  assign done_o         = (state == S_DONE);
  assign pc_wr_o        = done_o;
  assign pc_o           = vec_q;
  assign sp_wr_o        = done_o;
  assign sp_new_o       = sp_cur;
  assign busy_o         = (state != S_IDLE);
endmodule

// File: rtl/isc_checker.sv
module isc_checker #(
  parameter int FW    = 16,
  parameter int SP_W  = 16,
  parameter int NUM_W = 6,
  parameter int I_BIT = 6,
  parameter int D_BIT = 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             int_accept_i,
  input logic             busy_o,
  input logic             ack_rd_o,
  input logic             clr_pend_o,
  input logic             flg_wr_o,
  input logic [FW-1:0]    flg_o,
  input logic             stk_valid_o,
  input logic             stk_ready_i,
  input logic [SP_W-1:0]  stk_addr_o,
  input logic [FW-1:0]    stk_data_o,
  input logic             ipl_wr_o,
  input logic             vec_rd_valid_o,
  input logic             vec_rd_ready_i,
  input logic [NUM_W-1:0] vec_rd_num_o,
  input logic             pc_wr_o,
  input logic             sp_wr_o,
  input logic             done_o
);
  p_ack_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && int_accept_i) |=> ack_rd_o);

  p_clear_after_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ack_rd_o |=> (clr_pend_o && !ack_rd_o));

  p_flags_cleared_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flg_wr_o |-> (!flg_o[I_BIT] && !flg_o[D_BIT]));

  p_push_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stk_valid_o && !stk_ready_i) |=>
      (stk_valid_o && $stable(stk_addr_o) && $stable(stk_data_o)));

  p_vec_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_rd_valid_o && !vec_rd_ready_i) |=> (vec_rd_valid_o && $stable(vec_rd_num_o)));

  p_done_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (pc_wr_o && sp_wr_o && !stk_valid_o && !vec_rd_valid_o));

  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && int_accept_i) |=> !ack_rd_o);

  p_strobe_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_rd_o, clr_pend_o, flg_wr_o, ipl_wr_o, done_o}));
endmodule

bind isc_entry_seq isc_checker #(
  .FW(FW), .SP_W(SP_W), .NUM_W(NUM_W), .I_BIT(I_BIT), .D_BIT(D_BIT)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .int_accept_i   (int_accept_i),
  .busy_o         (busy_o),
  .ack_rd_o       (ack_rd_o),
  .clr_pend_o     (clr_pend_o),
  .flg_wr_o       (flg_wr_o),
  .flg_o          (flg_o),
  .stk_valid_o    (stk_valid_o),
  .stk_ready_i    (stk_ready_i),
  .stk_addr_o     (stk_addr_o),
  .stk_data_o     (stk_data_o),
  .ipl_wr_o       (ipl_wr_o),
  .vec_rd_valid_o (vec_rd_valid_o),
  .vec_rd_ready_i (vec_rd_ready_i),
  .vec_rd_num_o   (vec_rd_num_o),
  .pc_wr_o        (pc_wr_o),
  .sp_wr_o        (sp_wr_o),
  .done_o         (done_o)
);

// File: tb/tb_isc_entry_seq.sv
module tb_isc_entry_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        int_accept_i = 1'b0;
  logic        sw_int_i = 1'b0;
  logic        ack_rd_o;
  logic [19:0] ack_addr_o;
  logic [5:0]  ack_num_i = '0;
  logic [2:0]  ack_lvl_i = '0;
  logic        clr_pend_o;
  logic [5:0]  clr_num_o;
  logic [15:0] flg_i = '0;
  logic        flg_wr_o;
  logic [15:0] flg_o;
  logic [15:0] isp_i = 16'h0400;
  logic [15:0] usp_i = 16'h0800;
  logic [19:0] pc_i = '0;
  logic        stk_valid_o;
  logic        stk_ready_i = 1'b1;
  logic [15:0] stk_addr_o;
  logic [15:0] stk_data_o;
  logic        ipl_wr_o;
  logic [2:0]  ipl_o;
  logic        vec_rd_valid_o;
  logic        vec_rd_ready_i = 1'b1;
  logic [5:0]  vec_rd_num_o;
  logic [19:0] vec_rd_data_i;
  logic        pc_wr_o;
  logic [19:0] pc_o;
  logic        sp_wr_o;
  logic [15:0] sp_new_o;
  logic        busy_o;
  logic        done_o;

  int checks = 0;
  int failures = 0;
  int cyc_total = 0;

  always #2 clk = ~clk;

  assign vec_rd_data_i = 20'h0F000 + {12'd0, vec_rd_num_o, 2'b00};

  isc_entry_seq dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // {sw, num, lvl, flags, pc}
  localparam int NV = 6;
  localparam logic [45:0] VECS [NV] = '{
    {1'b0, 6'd5,  3'd3, 16'h00C2, 20'h12345},
    {1'b1, 6'd40, 3'd0, 16'h00C2, 20'hABCDE},
    {1'b1, 6'd31, 3'd7, 16'hFFFF, 20'h00010},
    {1'b0, 6'd63, 3'd5, 16'h0080, 20'hF0001},
    {1'b1, 6'd32, 3'd2, 16'h0040, 20'h5A5A5},
    {1'b1, 6'd63, 3'd1, 16'hFF82, 20'h80000}
  };

  task automatic run_seq(input logic sw, input logic [5:0] num, input logic [2:0] lvl,
                         input logic [15:0] flg, input logic [19:0] pc,
                         input bit stall, input bit poke);
    logic [15:0] ef;
    logic [15:0] sp0;
    logic [15:0] ea [3];
    logic [15:0] ed [3];
    int          pushes;
    bit          pv;
    logic [15:0] pa, pd;
    bit          vpv;
    logic [5:0]  pn;
    bit          finished;
    ef = flg & ~16'h0042;
    if (!(sw && num >= 6'd32)) ef[7] = 1'b0;
    sp0 = ef[7] ? usp_i : isp_i;
    ea[0] = sp0 - 16'd1; ed[0] = flg;
    ea[1] = sp0 - 16'd2; ed[1] = {12'd0, pc[19:16]};
    ea[2] = sp0 - 16'd3; ed[2] = pc[15:0];
    pushes = 0; pv = 0; vpv = 0; pa = '0; pd = '0; pn = '0; finished = 0;

    @(negedge clk);
    sw_int_i = sw; ack_num_i = num; ack_lvl_i = lvl; flg_i = flg; pc_i = pc;
    int_accept_i = 1'b1;
    for (int c = 1; c <= 60 && !finished; c++) begin
      @(negedge clk);
      int_accept_i = poke && (c == 3);
      stk_ready_i = !stall || (c % 2 == 0);
      vec_rd_ready_i = !stall || (c % 3 == 0);
      if (pv) chk(stk_valid_o && stk_addr_o == pa && stk_data_o == pd,
                  "R6 push held under back-pressure", {stk_addr_o, stk_data_o}, {pa, pd});
      if (vpv) chk(vec_rd_valid_o && vec_rd_num_o == pn,
                   "R8 vector request held", {26'd0, vec_rd_num_o}, {26'd0, pn});
      pv = stk_valid_o && !stk_ready_i; pa = stk_addr_o; pd = stk_data_o;
      vpv = vec_rd_valid_o && !vec_rd_ready_i; pn = vec_rd_num_o;
      if (ack_rd_o) begin
        chk(c == 1, "R1 ack read cycle", c, 1);
        chk(ack_addr_o == 20'h0, "R1 ack address", {12'd0, ack_addr_o}, 0);
      end
      if (clr_pend_o) begin
        chk(c == 2, "R2 clear cycle", c, 2);
        chk(clr_num_o == num, "R2 cleared number", {26'd0, clr_num_o}, {26'd0, num});
      end
      if (flg_wr_o) begin
        chk(flg_o[6] == 0 && flg_o[1] == 0 && flg_o[15:8] == flg[15:8] && flg_o[5:2] == flg[5:2]
            && flg_o[0] == flg[0], "R3 flag word", {16'd0, flg_o}, {16'd0, ef});
        chk(flg_o[7] == ef[7], "R4 stack select bit", {31'd0, flg_o[7]}, {31'd0, ef[7]});
      end
      if (stk_valid_o && stk_ready_i) begin
        if (pushes < 3)
          chk(stk_addr_o == ea[pushes] && stk_data_o == ed[pushes], "R5 push addr/data",
              {stk_addr_o, stk_data_o}, {ea[pushes], ed[pushes]});
        pushes++;
      end
      if (ipl_wr_o) chk(ipl_o == lvl, "R7 level written", {29'd0, ipl_o}, {29'd0, lvl});
      if (vec_rd_valid_o && vec_rd_ready_i)
        chk(vec_rd_num_o == num, "R8 vector index", {26'd0, vec_rd_num_o}, {26'd0, num});
      if (done_o) begin
        finished = 1;
        chk(pushes == 3, "R5 push count", pushes, 3);
        chk(pc_wr_o && pc_o == 20'h0F000 + {12'd0, num, 2'b00}, "R8 new PC",
            {12'd0, pc_o}, {12'd0, 20'h0F000 + {12'd0, num, 2'b00}});
        chk(sp_wr_o && sp_new_o == sp0 - 16'd3, "R9 final SP", {16'd0, sp_new_o}, {16'd0, sp0 - 16'd3});
        if (!stall) chk(c == 9, "R9 done latency", c, 9);
      end
    end
    chk(finished, "R9 sequence finished", {31'd0, finished}, 1);
    int_accept_i = 1'b0; stk_ready_i = 1'b1; vec_rd_ready_i = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      if (poke) chk(!ack_rd_o && !busy_o && !stk_valid_o, "R10 busy accept ignored",
                    {29'd0, ack_rd_o, busy_o, stk_valid_o}, 0);
    end
  endtask

  initial begin
    #1;
    chk(!busy_o && !ack_rd_o && !stk_valid_o && !vec_rd_valid_o && !done_o,
        "R11 state in reset", {27'd0, busy_o, ack_rd_o, stk_valid_o, vec_rd_valid_o, done_o}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !clr_pend_o && !flg_wr_o && !ipl_wr_o && !pc_wr_o && !sp_wr_o,
        "R11 idle after reset", {31'd0, busy_o}, 0);
    for (int i = 0; i < NV; i++)
      run_seq(VECS[i][45], VECS[i][44:39], VECS[i][38:36], VECS[i][35:20], VECS[i][19:0], 0, 0);
    // back-pressure on both ports
    run_seq(1'b1, 6'd33, 3'd6, 16'h00C3, 20'h3C3C3, 1, 0);
    // accept strobe while busy
    run_seq(1'b0, 6'd12, 3'd4, 16'h0042, 20'h01234, 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cyc_total++;
    if (cyc_total > 20000) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule